// File: doc/BRIEF.md
# Hall Commutation Decoder

This block turns the three Hall-sensor levels of a brushless motor, placed 120 electrical degrees apart, into six gate requests for a three-phase bridge: a high-side and a low-side request for each of phases A, B and C. On every valid Hall code one phase is sourcing, one is sinking and one is floating. Direction, a dynamic brake, a drive-disable, a fault-coast flag, a decay-mode select, a synchronous-rectification select and a chop on/off signal change the decoded pattern.

The chop input comes from an external PWM or current-limit loop. While chop is on, the selected source/sink pair is driven. While chop is off, the off-cycle pattern is chosen by the decay-mode and synchronous-rectification inputs. A priority chain gives a safe result when several overrides are active at once. The decode is combinational. It is followed by a parameterised register stage, so the gate requests, the sector number and the bad-code flag all appear a fixed number of clocks after the inputs. Dead-time insertion and Hall filtering are done elsewhere.

Top module: `hall_comm_decoder`

## Requirements
- R1: With `dir` equal to the parameter `FWD_LEVEL`, the Hall code {H1,H2,H3} = `hall[2:0]` maps as follows: 101 to sector 0 (A high, B low), 100 to sector 1 (A high, C low), 110 to sector 2 (B high, C low), 010 to sector 3 (B high, A low), 011 to sector 4 (C high, A low) and 001 to sector 5 (C high, B low). The sector number appears on `sector`. Gate vectors use bit 0 = A, bit 1 = B and bit 2 = C.
- R2: With `dir` not equal to `FWD_LEVEL`, the sourcing and sinking phases of each sector are exchanged, and `sector` is unchanged.
- R3: When no override is active and `chop_on` = 1, exactly the selected high-side gate and the selected low-side gate are on.
- R4: When chop is off with `decay_slow` = 0 and `sync_rect` = 0, all six gates are off.
- R5: When chop is off with `decay_slow` = 1 and `sync_rect` = 0, only the selected low-side gate is on.
- R6: When chop is off with `decay_slow` = 0 and `sync_rect` = 1, the opposite pair is on: the high side of the sinking phase and the low side of the sourcing phase.
- R7: When chop is off with `decay_slow` = 1 and `sync_rect` = 1, the low sides of both active phases are on and all high sides are off.
- R8: Hall codes 000 and 111 turn all gates off, set `hall_bad` to 1 and report `sector` = 7. `hall_bad` and `sector` follow the Hall code whatever the other inputs are.
- R9: When `brake_n` = 0 and no higher-priority override is active, all three low-side gates are on and all high-side gates are off. The chop, decay and rectification inputs have no effect during braking.
- R10: The override priority, from highest to lowest, is `drive_dis` = 1, then `fault_coast` = 1, then a bad Hall code, then brake, then normal commutation. Each of the first three turns all gates off.
- R11: No phase ever has its high-side and low-side request on at the same time, for any input combination.
- R12: All outputs are registered through `OUT_STAGES` register stages, so an input change reaches the outputs exactly `OUT_STAGES` clocks later. An active-low `rst_n` clears every stage to zero at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output stages |
| hall | input | 3 | Hall levels {H1,H2,H3} |
| dir | input | 1 | Rotation direction; forward when equal to FWD_LEVEL |
| brake_n | input | 1 | Active-low dynamic brake |
| drive_dis | input | 1 | Forces coast; highest priority |
| decay_slow | input | 1 | Off-cycle decay select: 1 slow, 0 fast |
| sync_rect | input | 1 | Enables synchronous rectification in the off cycle |
| chop_on | input | 1 | PWM chop phase: 1 on, 0 off |
| fault_coast | input | 1 | External fault request to coast |
| gate_hi | output | 3 | High-side gate requests {C,B,A} |
| gate_lo | output | 3 | Low-side gate requests {C,B,A} |
| sector | output | 3 | Decoded sector 0 to 5, or 7 for a bad code |
| hall_bad | output | 1 | Illegal Hall code flag |

## Verification
The bench builds the decoder with `OUT_STAGES` = 2 and `FWD_LEVEL` = 1. The two-deep pipeline lets the bench observe a cycle in which the old value is still held while the new decode is one stage in. With that depth, the bench can also see a reset in the middle of a run clear both stages at once. All 1024 combinations of the ten control inputs are walked, which covers every overlap of overrides against the off-cycle modes and every decay pattern in the reverse direction.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
   localparam int unsigned NPH   = 3;
   localparam int unsigned SEC_W = 3;
   localparam int unsigned HALL_W = 3;

   typedef logic [NPH-1:0]   phase_vec_t;
   typedef logic [SEC_W-1:0] sector_t;

   localparam sector_t SECTOR_NONE = sector_t'(7);

   // off-cycle behaviour, encoded as {sync_rect, decay_slow}
   typedef enum logic [1:0] {
      OFF_ALL_FLOAT = 2'b00,
      OFF_SINK_LOW  = 2'b01,
      OFF_REVERSED  = 2'b10,
      OFF_BOTH_LOW  = 2'b11
   } off_mode_e;

   typedef struct packed {
      phase_vec_t hi;
      phase_vec_t lo;
      sector_t    sector;
      logic       bad;
   } gate_word_t;

   localparam int unsigned WORD_W = $bits(gate_word_t);
endpackage

// File: rtl/hcd_sector_decode.sv
module hcd_sector_decode
   import hcd_pkg::*;
#(
   parameter logic FWD_LEVEL = 1'b1
) (
   input  logic [HALL_W-1:0] hall,
   input  logic              dir,
   output phase_vec_t        src,
   output phase_vec_t        snk,
   output sector_t           sector,
   output logic              bad
);
   logic [1:0] hi_idx;
   logic [2:0] lo_sum;
   logic [1:0] lo_idx;
   phase_vec_t fwd_hi, fwd_lo;
   logic       fwd;

   always_comb begin
      bad    = 1'b0;
      sector = SECTOR_NONE;
      unique case (hall)
         3'b101:  sector = sector_t'(0);
         3'b100:  sector = sector_t'(1);
         3'b110:  sector = sector_t'(2);
         3'b010:  sector = sector_t'(3);
         3'b011:  sector = sector_t'(4);
         3'b001:  sector = sector_t'(5);
         default: bad    = 1'b1;
      endcase
   end

   // sourcing phase advances every two sectors; sink sits one or two ahead
   assign hi_idx = sector[2:1];
   assign lo_sum = {1'b0, hi_idx} + 3'd1 + {2'b00, sector[0]};
   assign lo_idx = (lo_sum >= 3'd3) ? 2'(lo_sum - 3'd3) : lo_sum[1:0];

   for (genvar p = 0; p < NPH; p++) begin : g_phase
      assign fwd_hi[p] = !bad && (hi_idx == 2'(p));
      assign fwd_lo[p] = !bad && (lo_idx == 2'(p));
   end

   assign fwd = (dir == FWD_LEVEL);
   assign src = fwd ? fwd_hi : fwd_lo;
   assign snk = fwd ? fwd_lo : fwd_hi;
endmodule

// File: rtl/hcd_gate_mux.sv
module hcd_gate_mux
   import hcd_pkg::*;
(
   input  phase_vec_t src,
   input  phase_vec_t snk,
   input  logic       bad,
   input  logic       drive_dis,
   input  logic       fault_coast,
   input  logic       brake_n,
   input  logic       chop_on,
   input  logic       decay_slow,
   input  logic       sync_rect,
   output phase_vec_t hi,
   output phase_vec_t lo
);
   off_mode_e off_mode;

   assign off_mode = off_mode_e'({sync_rect, decay_slow});

   always_comb begin
      hi = '0;
      lo = '0;
      if (drive_dis || fault_coast || bad) begin
         hi = '0;
         lo = '0;
      end else if (!brake_n) begin
         lo = '1;
      end else if (chop_on) begin
         hi = src;
         lo = snk;
      end else begin
         unique case (off_mode)
            OFF_ALL_FLOAT: ;
            OFF_SINK_LOW:  lo = snk;
            OFF_REVERSED: begin
               hi = snk;
               lo = src;
            end
            OFF_BOTH_LOW:  lo = src | snk;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/hcd_out_pipe.sv
module hcd_out_pipe #(
   parameter int unsigned STAGES = 1,
   parameter int unsigned W      = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES == 0) begin : g_comb
      assign q = d;
   end else begin : g_reg
      logic [STAGES-1:0][W-1:0] stg;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg <= '0;
         end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
         end
      end

      assign q = stg[STAGES-1];

      // first stage captures the decoded word one clock later
      p_stage_capture_r12: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> stg[0] == $past(d));
   end
endmodule

// File: rtl/hall_comm_decoder.sv
module hall_comm_decoder
   import hcd_pkg::*;
#(
   parameter int unsigned OUT_STAGES = 1,
   parameter logic        FWD_LEVEL  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  hall,
   input  logic        dir,
   input  logic        brake_n,
   input  logic        drive_dis,
   input  logic        decay_slow,
   input  logic        sync_rect,
   input  logic        chop_on,
   input  logic        fault_coast,
   output logic [2:0]  gate_hi,
   output logic [2:0]  gate_lo,
   output logic [2:0]  sector,
   output logic        hall_bad
);
   localparam int unsigned MAX_STAGES = 4;

   if (OUT_STAGES > MAX_STAGES) begin : g_chk_depth
      $error("hall_comm_decoder: OUT_STAGES exceeds MAX_STAGES");
   end

   phase_vec_t src_c, snk_c, hi_c, lo_c;
   sector_t    sec_c;
   logic       bad_c;
   gate_word_t word_c, word_q;

   hcd_sector_decode #(.FWD_LEVEL(FWD_LEVEL)) i_decode (
      .hall   (hall),
      .dir    (dir),
      .src    (src_c),
      .snk    (snk_c),
      .sector (sec_c),
      .bad    (bad_c)
   );

   hcd_gate_mux i_mux (
      .src         (src_c),
      .snk         (snk_c),
      .bad         (bad_c),
      .drive_dis   (drive_dis),
      .fault_coast (fault_coast),
      .brake_n     (brake_n),
      .chop_on     (chop_on),
      .decay_slow  (decay_slow),
      .sync_rect   (sync_rect),
      .hi          (hi_c),
      .lo          (lo_c)
   );

   assign word_c = '{hi: hi_c, lo: lo_c, sector: sec_c, bad: bad_c};

   hcd_out_pipe #(.STAGES(OUT_STAGES), .W(WORD_W)) i_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (word_c),
      .q     (word_q)
   );

   assign gate_hi  = word_q.hi;
   assign gate_lo  = word_q.lo;
   assign sector   = word_q.sector;
   assign hall_bad = word_q.bad;

   p_no_shoot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_c & lo_c) == '0);

   p_disable_coast_r10: assert property (@(posedge clk) disable iff (!rst_n)
      drive_dis |-> (hi_c == '0 && lo_c == '0));

   p_bad_code_coast_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bad_c |-> (hi_c == '0 && lo_c == '0 && sec_c == SECTOR_NONE));

   p_brake_lows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!drive_dis && !fault_coast && !bad_c && !brake_n) |-> (lo_c == '1 && hi_c == '0));

   p_one_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!drive_dis && !fault_coast && !bad_c && brake_n && chop_on)
         |-> ($countones(hi_c) == 1 && $countones(lo_c) == 1));
endmodule

// File: tb/test_hall_comm_decoder.sv
module test_hall_comm_decoder;
   localparam int unsigned LAT = 2;
   localparam int NV = 25;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n;
   logic [2:0] hall;
   logic dir, brake_n, drive_dis, decay_slow, sync_rect, chop_on, fault_coast;
   logic [2:0] gate_hi, gate_lo, sector;
   logic       hall_bad;
   logic [9:0] obs;

   int n_vec = 0;
   int n_bad = 0;

   hall_comm_decoder #(.OUT_STAGES(LAT), .FWD_LEVEL(1'b1)) i_hall_comm_decoder (
      .clk(clk), .rst_n(rst_n), .hall(hall), .dir(dir), .brake_n(brake_n),
      .drive_dis(drive_dis), .decay_slow(decay_slow), .sync_rect(sync_rect),
      .chop_on(chop_on), .fault_coast(fault_coast), .gate_hi(gate_hi),
      .gate_lo(gate_lo), .sector(sector), .hall_bad(hall_bad)
   );

   assign obs = {gate_hi, gate_lo, sector, hall_bad};

   typedef struct packed {
      logic [2:0] hall;
      logic dir, brk_n, dis, slow, sr, chop, flt;
      logic [2:0] hi, lo, sec;
      logic bad;
      logic [3:0] req;
   } vec_t;

   // hall dir brk_n dis slow sr chop flt | hi lo sec bad | requirement
   localparam vec_t VEC [NV] = '{
      '{3'b101,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b001,3'b010,3'd0,1'b0,4'd1}, // R1
      '{3'b100,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b001,3'b100,3'd1,1'b0,4'd1}, // R1
      '{3'b110,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b010,3'b100,3'd2,1'b0,4'd1}, // R1
      '{3'b010,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b010,3'b001,3'd3,1'b0,4'd1}, // R1
      '{3'b011,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b100,3'b001,3'd4,1'b0,4'd1}, // R1
      '{3'b001,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b100,3'b010,3'd5,1'b0,4'd3}, // R3
      '{3'b101,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b010,3'b001,3'd0,1'b0,4'd2}, // R2
      '{3'b110,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b100,3'b010,3'd2,1'b0,4'd2}, // R2
      '{3'b011,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b001,3'b100,3'd4,1'b0,4'd2}, // R2
      '{3'b100,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,3'd1,1'b0,4'd4}, // R4
      '{3'b100,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'b000,3'b100,3'd1,1'b0,4'd5}, // R5
      '{3'b100,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,3'b100,3'b001,3'd1,1'b0,4'd6}, // R6
      '{3'b100,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'b000,3'b101,3'd1,1'b0,4'd7}, // R7
      '{3'b010,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,3'b010,3'b001,3'd3,1'b0,4'd6}, // R6 reversed
      '{3'b010,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'b000,3'b011,3'd3,1'b0,4'd7}, // R7 reversed
      '{3'b010,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'b000,3'b010,3'd3,1'b0,4'd5}, // R5 reversed
      '{3'b000,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,3'b000,3'd7,1'b1,4'd8}, // R8
      '{3'b111,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,3'b000,3'd7,1'b1,4'd8}, // R8
      '{3'b101,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,3'b111,3'd0,1'b0,4'd9}, // R9
      '{3'b110,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,3'b000,3'b111,3'd2,1'b0,4'd9}, // R9 chop ignored
      '{3'b101,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,3'b000,3'b000,3'd0,1'b0,4'd10}, // R10 disable over brake
      '{3'b110,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,3'b000,3'b000,3'd2,1'b0,4'd10}, // R10 fault over brake
      '{3'b000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,3'b000,3'd7,1'b1,4'd10}, // R10 bad code over brake
      '{3'b111,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,3'b000,3'b000,3'd7,1'b1,4'd10}, // R10 flag under disable
      '{3'b001,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,3'b000,3'b000,3'd5,1'b0,4'd10}  // R10 fault coast
   };

   task automatic check(input int req, input string what, input logic [9:0] got,
                        input logic [9:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      hall = v.hall; dir = v.dir; brake_n = v.brk_n; drive_dis = v.dis;
      decay_slow = v.slow; sync_rect = v.sr; chop_on = v.chop; fault_coast = v.flt;
   endtask

   task automatic settle();
      repeat (LAT) @(posedge clk);
      #2;
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      report();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      hall = 3'b101; dir = 1'b1; brake_n = 1'b1; drive_dis = 1'b0;
      decay_slow = 1'b0; sync_rect = 1'b0; chop_on = 1'b1; fault_coast = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      // R12: reset state holds every output at zero
      check(12, "reset state", obs, 10'b000_000_000_0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         settle();
         check(int'(VEC[i].req), $sformatf("vector %0d", i), obs,
               {VEC[i].hi, VEC[i].lo, VEC[i].sec, VEC[i].bad});
      end

      // R12: latency of exactly LAT clocks
      apply(VEC[0]);
      settle();
      apply(VEC[2]);
      @(posedge clk); #2;
      check(12, "old value one clock in", obs, {3'b001, 3'b010, 3'd0, 1'b0});
      @(posedge clk); #2;
      check(12, "new value after two clocks", obs, {3'b010, 3'b100, 3'd2, 1'b0});

      // R12: asynchronous reset mid-run clears both stages
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(12, "async clear", obs, 10'd0);
      @(posedge clk); #2;
      check(12, "held in reset", obs, 10'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      check(12, "first clock after release", obs, 10'd0);
      @(posedge clk); #2;
      check(12, "refilled after release", obs, {3'b010, 3'b100, 3'd2, 1'b0});

      // R11: no phase ever drives both gates, across every input combination
      for (int c = 0; c < 1024; c++) begin
         @(negedge clk);
         {hall, dir, brake_n, drive_dis, decay_slow, sync_rect, chop_on, fault_coast} = 10'(c);
         settle();
         check(11, $sformatf("overlap at combination %0d", c),
               {7'd0, gate_hi & gate_lo}, 10'd0);
      end

      report();
      $finish;
   end
endmodule